// File: doc/BRIEF.md
# Converter Fault Supervisor with Hiccup Restart

This block is the digital sequencing core of a step-down converter controller. Every fault input is a clean flag, already synchronous to the clock. The bias undervoltage, input undervoltage and over-temperature flags form the blocking class. The short-circuit and over-current flags form the self-clearing class. The block decides when the external gate drivers may switch, keeps a digital soft-start ramp code that stands in for the reference during start-up, and produces a power-good flag.

Any fault seen while the drivers run does three things in the same clock: the drivers stop, the soft-start code drops to zero, and a fixed hiccup wait of `HICCUP_TICKS` clocks begins. When the wait ends, a restart is tried as soon as no blocking fault is present. A short circuit or over-current that persists is therefore retried once per period. A blocking fault holds the block off for as long as it lasts. Pulling the enable low puts the block to sleep and overrides everything else.

Top module: `buck_fault_supervisor`

## Requirements
- R1: Under reset, `drv_en`, `ss_code` and `pwr_good` are all 0.
- R2: If `en` is low at a clock edge, then after that edge `drv_en` is 0 and `ss_code` is 0.
- R3: From sleep, when `en` is high and no blocking fault is present, `drv_en` is 0 after the first edge and 1 after the second edge.
- R4: While the drivers run and no fault is present, each edge with `ramp_tick` high raises `ss_code` by one, saturating at 2^SS_W-1. An edge without `ramp_tick` leaves `ss_code` unchanged.
- R5: Any fault flag high at an edge where `drv_en` is 1 makes `drv_en` 0 and `ss_code` 0 after that edge.
- R6: After a fault edge with no blocking fault afterwards, `drv_en` returns to 1 exactly HICCUP_TICKS+1 edges later. Faults that arrive during the wait do not lengthen it.
- R7: While any of `bias_uv`, `input_uv` or `over_temp` is high, the drivers stay off even after the wait has ended. `drv_en` rises at the first edge after the last of them clears.
- R8: A `short_flag` or `over_curr` that stays high gives a repeating pattern with a period of HICCUP_TICKS+2 clocks: `drv_en` is high for one clock and low for HICCUP_TICKS+1 clocks.
- R9: `pwr_good` is 1 only when the block is regulating, `ss_code` has reached PG_CODE = 2*REF_CODE, and `fb_in_window` is high. A change in `fb_in_window` reaches `pwr_good` in the same cycle, with no clock delay.
- R10: `en` low takes priority over faults and over an ongoing hiccup wait. After re-enable, start-up follows the timing of R3 and does not finish the earlier wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low puts the block to sleep |
| ramp_tick | input | 1 | One soft-start step per high cycle |
| bias_uv | input | 1 | Bias supply undervoltage (blocking) |
| input_uv | input | 1 | Input supply undervoltage (blocking) |
| over_temp | input | 1 | Over-temperature (blocking) |
| short_flag | input | 1 | Output short detected (self-clearing) |
| over_curr | input | 1 | Over-current detected (self-clearing) |
| fb_in_window | input | 1 | Feedback is inside the regulation window |
| drv_en | output | 1 | Gate drivers allowed to switch |
| ss_code | output | SS_W | Soft-start ramp code |
| pwr_good | output | 1 | Output in regulation |

## Verification
A hiccup counter that is off by one shows up as a restart edge one clock early or late, and the first retry exposes it within HICCUP_TICKS+2 clocks. A lost fault-class decision shows up in two ways: the drivers come back while a blocking flag is still high, or a persistent short stops producing its one-clock retry pulse. A wrong soft-start state shows in `ss_code` at the next tick, or in `pwr_good` rising before the code reaches PG_CODE. Each fault flag is swept on its own and the off time is measured, so a flag that is wired to the wrong class or not wired at all appears within one period.

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor #(
  parameter int SS_W         = 10,
  parameter int REF_CODE     = 400,
  parameter int HICCUP_TICKS = 120000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            ramp_tick,
  input  logic            bias_uv,
  input  logic            input_uv,
  input  logic            over_temp,
  input  logic            short_flag,
  input  logic            over_curr,
  input  logic            fb_in_window,
  output logic            drv_en,
  output logic [SS_W-1:0] ss_code,
  output logic            pwr_good
);
  localparam int PG_CODE = 2 * REF_CODE;
  localparam int CW      = $clog2(HICCUP_TICKS + 1);
  localparam logic [SS_W-1:0] SS_MAX  = {SS_W{1'b1}};
  localparam logic [SS_W-1:0] SS_PG   = SS_W'(PG_CODE);
  localparam logic [CW-1:0]   CNT_END = CW'(HICCUP_TICKS - 1);

  typedef enum logic [2:0] {S_SLEEP, S_WAIT, S_SOFT, S_RUN, S_HIC} st_t;

  st_t             st;
  logic [CW-1:0]   hic_cnt;
  logic [SS_W-1:0] ss_q;

  wire blk_fault = bias_uv | input_uv | over_temp;
  wire trip_fault = short_flag | over_curr;
  wire any_fault = blk_fault | trip_fault;
  wire driving = (st == S_SOFT) || (st == S_RUN);
  wire [SS_W-1:0] ss_step = (ramp_tick && ss_q != SS_MAX) ? ss_q + 1'b1 : ss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_SLEEP;
      ss_q    <= '0;
      hic_cnt <= '0;
    end else if (!en) begin
      st      <= S_SLEEP;
      ss_q    <= '0;
      hic_cnt <= '0;
    end else begin
      case (st)
        S_SLEEP: st <= S_WAIT;
        S_WAIT:  if (!blk_fault) st <= S_SOFT;
        S_SOFT, S_RUN: begin
          if (any_fault) begin
            st      <= S_HIC;
            ss_q    <= '0;
            hic_cnt <= '0;
          end else begin
            ss_q <= ss_step;
            if (ss_step >= SS_PG) st <= S_RUN;
          end
        end
        S_HIC: begin
          hic_cnt <= hic_cnt + 1'b1;
          if (hic_cnt == CNT_END) st <= S_WAIT;
        end
        default: st <= S_SLEEP;
      endcase
    end
  end

  assign drv_en   = driving;
  assign ss_code  = ss_q;
  assign pwr_good = (st == S_RUN) && fb_in_window;

  // R2
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drv_en && ss_code == '0));

  // R5
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && drv_en && (blk_fault || trip_fault)) |=> (!drv_en && ss_code == '0));

  // R4
  ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && drv_en && !ramp_tick && !blk_fault && !trip_fault) |=> $stable(ss_code));

  // R7
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en && blk_fault) |=> !drv_en);

  // R9
  pg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> (ss_code >= SS_PG && fb_in_window));

  // R1
  always_comb if (!rst_n) reset_out_chk: assert (!drv_en && !pwr_good);
endmodule

// File: tb/buck_fault_supervisor_bench.sv
module buck_fault_supervisor_bench;
  localparam int SS_W = 5;
  localparam int REF  = 6;
  localparam int PG   = 2 * REF;
  localparam int H    = 7;
  localparam int SMAX = (1 << SS_W) - 1;

  logic clk = 0;
  logic rst_n = 0, en = 0, ramp_tick = 0;
  logic bias_uv = 0, input_uv = 0, over_temp = 0, short_flag = 0, over_curr = 0;
  logic fb_in_window = 0;
  logic drv_en, pwr_good;
  logic [SS_W-1:0] ss_code;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  buck_fault_supervisor #(.SS_W(SS_W), .REF_CODE(REF), .HICCUP_TICKS(H)) u_buck_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .en(en), .ramp_tick(ramp_tick),
    .bias_uv(bias_uv), .input_uv(input_uv), .over_temp(over_temp),
    .short_flag(short_flag), .over_curr(over_curr), .fb_in_window(fb_in_window),
    .drv_en(drv_en), .ss_code(ss_code), .pwr_good(pwr_good));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_flag(input int f, input logic v);
    case (f)
      0: bias_uv = v;
      1: input_uv = v;
      2: over_temp = v;
      3: short_flag = v;
      default: over_curr = v;
    endcase
  endtask

  task automatic count_off(output int n);
    n = 0;
    do begin tick(); n++; end while (!drv_en && n < 200);
  endtask

  initial begin
    int n;
    repeat (3) tick();
    chk(!drv_en && ss_code == 0 && !pwr_good, "R1 reset outputs", {drv_en, pwr_good}, 0);
    rst_n = 1;
    tick();
    chk(!drv_en, "R2 en low stays off", drv_en, 0);
    en = 1;
    tick();
    chk(!drv_en, "R3 first edge off", drv_en, 0);
    tick();
    chk(drv_en, "R3 second edge on", drv_en, 1);
    chk(ss_code == 0, "R4 no tick no step", ss_code, 0);

    fb_in_window = 1;
    for (int i = 1; i <= SMAX + 4; i++) begin
      int e;
      ramp_tick = 1;
      tick();
      e = (i > SMAX) ? SMAX : i;
      chk(ss_code == e, "R4 ramp step/saturate", ss_code, e);
      chk(pwr_good == (e >= PG), "R9 pg vs level", pwr_good, e >= PG);
    end
    ramp_tick = 0;
    tick();
    chk(ss_code == SMAX, "R4 hold without tick", ss_code, SMAX);
    fb_in_window = 0; #1;
    chk(!pwr_good, "R9 pg drops out of window", pwr_good, 0);
    fb_in_window = 1; #1;
    chk(pwr_good, "R9 pg back in window", pwr_good, 1);

    for (int f = 0; f < 5; f++) begin
      set_flag(f, 1);
      tick();
      chk(!drv_en && ss_code == 0 && !pwr_good, "R5 fault turns off", drv_en, 0);
      set_flag(f, 0);
      count_off(n);
      chk(n == H + 1, "R6 hiccup length per flag", n, H + 1);
    end

    short_flag = 1; tick(); short_flag = 0;
    tick(); tick();
    over_curr = 1; tick(); over_curr = 0;
    count_off(n);
    chk(n + 3 == H + 1, "R6 no extension", n + 3, H + 1);

    input_uv = 1;
    tick();
    n = 0;
    for (int i = 0; i < H + 4; i++) begin tick(); if (drv_en) n++; end
    chk(n == 0, "R7 blocked while power fault", n, 0);
    input_uv = 0;
    tick();
    chk(drv_en, "R7 restart after clear", drv_en, 1);

    short_flag = 1;
    tick();
    for (int p = 0; p < 3; p++) begin
      count_off(n);
      chk(n == H + 1, "R8 retry period off time", n, H + 1);
      tick();
      chk(!drv_en, "R8 retry pulse one clock", drv_en, 0);
    end

    tick(); tick();
    en = 0;
    tick();
    chk(!drv_en && ss_code == 0, "R10 sleep overrides hiccup", drv_en, 0);
    short_flag = 0;
    en = 1;
    tick();
    chk(!drv_en, "R10 wake first edge off", drv_en, 0);
    tick();
    chk(drv_en, "R10 wake second edge on", drv_en, 1);

    en = 0;
    tick();
    chk(!drv_en && ss_code == 0 && !pwr_good, "R2 sleep from run", drv_en, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule